// File: doc/BRIEF.md
# Dual-Mode LCD Row/Column Drive Datapath

This block is the digital core of an 80-output LCD driver. It can run as a column (segment) driver or as a row (common) driver. In segment mode, display data arrives one bit or one 4-bit nibble per shift strobe. It collects in a shift register, and a latch strobe moves a complete line into the output register. In common mode, the segment shifter is bypassed. The output register becomes a bidirectional scan register that advances on each latch strobe. It can also be split into two independent 40-bit halves.

Every output carries a 3-bit drive-level index that selects one of six bias rails, V0 to V5. A latched 1 picks the selected rail and a latched 0 picks the non-selected rail. The AC frame input and the mode choose the exact rail. An active-low enable freezes the whole datapath so that idle cascaded chips draw no clock power. An active-low display-off input blanks all outputs without disturbing the stored line. All state is clocked by one system clock. The two strobes are single-cycle qualifiers, and reset is synchronous and active high.

Top module: `lcd_drive_core`

## Requirements
- R1: A synchronous reset clears the shift register and the output register to all zeros.
- R2: In segment mode with bus_wide=0 and shift_rev=0, each enabled shift strobe takes dat_i[0] into bit 0 and moves every bit up by one, so the first of 80 bits ends at bit 79.
- R3: In segment mode with bus_wide=1, each shift strobe moves the register by 4 bits. With shift_rev=0, dat_i[k] enters bit k. With shift_rev=1, dat_i[k] enters bit 76+k. 20 strobes fill the register.
- R4: In segment mode with bus_wide=0 and shift_rev=1, dat_i[0] enters bit 79 and bits move down by one, so the first of 80 bits ends at bit 0.
- R5: In segment mode, the output register changes only on an enabled latch strobe, which copies the whole shift register into it.
- R6: In common mode with dual_half=0, each enabled latch strobe shifts the output register by one. With shift_rev=0, din_l enters bit 0. With shift_rev=1, din_r enters bit 79. Shift strobes have no effect on the outputs.
- R7: In common mode with dual_half=1, bits 0..39 take din_l and bits 40..79 take din_r at the same time. The entry is at the low end of each half for shift_rev=0 and at the high end for shift_rev=1. No bit crosses between the halves.
- R8: While en_n is 1, shift and latch strobes have no effect.
- R9: An output whose register bit is 1 drives level 0 (V0) when frame_m=0 and level 5 (V5) when frame_m=1.
- R10: An output whose register bit is 0 drives level 2 (segment) or 1 (common) when frame_m=0, and level 3 (segment) or 4 (common) when frame_m=1.
- R11: While blank_n is 0, every output drives level 0, and the stored line reappears unchanged when blank_n returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_n | input | 1 | Chip enable, active low; high freezes all state |
| shift_stb | input | 1 | Single-cycle data shift qualifier |
| latch_stb | input | 1 | Single-cycle latch / common-scan qualifier |
| mode_common | input | 1 | 0 = segment driver, 1 = common driver |
| dual_half | input | 1 | Common mode: 1 splits the register into two halves |
| shift_rev | input | 1 | Shift direction select |
| bus_wide | input | 1 | Segment mode: 0 = 1-bit serial, 1 = 4-bit nibble |
| dat_i | input | 4 | Segment data input |
| din_l | input | 1 | Common data input, low end |
| din_r | input | 1 | Common data input, high end |
| frame_m | input | 1 | AC frame polarity |
| blank_n | input | 1 | Display off, active low |
| lvl_o | output | 240 | Drive-level index per output, output i at bits [3i+2:3i] |

## Verification
The properties assume that strobes are single-cycle qualifiers sampled on the rising clock edge. They also assume that mode, direction and width inputs are stable whenever a strobe is active, and that reset is held for at least one edge at the start. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. Configuration is changed only while both strobes are low, and a reset pulse comes before each change of mode. The level-index range property takes frame_m and blank_n as arbitrary and needs nothing further from them.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;

    localparam lvl_t LV_0 = 3'd0;
    localparam lvl_t LV_1 = 3'd1;
    localparam lvl_t LV_2 = 3'd2;
    localparam lvl_t LV_3 = 3'd3;
    localparam lvl_t LV_4 = 3'd4;
    localparam lvl_t LV_5 = 3'd5;
    localparam lvl_t LV_BLANK = LV_0;

    function automatic lvl_t pick_level(input logic bit_on, input logic m,
                                        input logic common, input logic show);
        lvl_t v;
        if (!show)
            v = LV_BLANK;
        else if (bit_on)
            v = m ? LV_5 : LV_0;
        else if (common)
            v = m ? LV_4 : LV_1;
        else
            v = m ? LV_3 : LV_2;
        return v;
    endfunction
endpackage

// File: rtl/lcd_seg_shifter.sv
module lcd_seg_shifter #(
    parameter int NOUT = 80,
    parameter int UNIT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            wide,
    input  logic            rev,
    input  logic [UNIT-1:0] dat,
    output logic [NOUT-1:0] sr_o
);
    typedef struct packed {
        logic [NOUT-1:0] sr;
    } seg_st_t;

    seg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (go) begin
            if (wide) begin
                if (rev) st_d.sr = {dat, st_q.sr[NOUT-1:UNIT]};
                else     st_d.sr = {st_q.sr[NOUT-UNIT-1:0], dat};
            end else begin
                if (rev) st_d.sr = {dat[0], st_q.sr[NOUT-1:1]};
                else     st_d.sr = {st_q.sr[NOUT-2:0], dat[0]};
            end
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign sr_o = st_q.sr;
endmodule

// File: rtl/lcd_line_reg.sv
module lcd_line_reg #(
    parameter int NOUT = 80
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            go,
    input  logic            common,
    input  logic            dual,
    input  logic            rev,
    input  logic            din_l,
    input  logic            din_r,
    input  logic [NOUT-1:0] sr_in,
    output logic [NOUT-1:0] lat_o
);
    localparam int HALF = NOUT / 2;

    typedef struct packed {
        logic [NOUT-1:0] lat;
    } line_st_t;

    line_st_t st_d, st_q;
    logic [HALF-1:0] lo_q, hi_q, lo_d, hi_d;

    assign lo_q = st_q.lat[HALF-1:0];
    assign hi_q = st_q.lat[NOUT-1:HALF];

    always_comb begin
        if (rev) begin
            lo_d = {din_l, lo_q[HALF-1:1]};
            hi_d = {din_r, hi_q[HALF-1:1]};
        end else begin
            lo_d = {lo_q[HALF-2:0], din_l};
            hi_d = {hi_q[HALF-2:0], din_r};
        end
    end

    always_comb begin
        st_d = st_q;
        if (go) begin
            if (!common)
                st_d.lat = sr_in;
            else if (dual)
                st_d.lat = {hi_d, lo_d};
            else if (rev)
                st_d.lat = {din_r, st_q.lat[NOUT-1:1]};
            else
                st_d.lat = {st_q.lat[NOUT-2:0], din_l};
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign lat_o = st_q.lat;
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_drv_pkg::*;
#(
    parameter int NOUT = 80
) (
    input  logic                  common,
    input  logic                  m,
    input  logic                  show,
    input  logic [NOUT-1:0]       lat,
    output logic [NOUT*LVL_W-1:0] lvl
);
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        assign lvl[i*LVL_W +: LVL_W] = pick_level(lat[i], m, common, show);
    end
endmodule

// File: rtl/lcd_drive_core.sv
module lcd_drive_core
    import lcd_drv_pkg::*;
#(
    parameter int NOUT = 80,
    parameter int UNIT = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en_n,
    input  logic                  shift_stb,
    input  logic                  latch_stb,
    input  logic                  mode_common,
    input  logic                  dual_half,
    input  logic                  shift_rev,
    input  logic                  bus_wide,
    input  logic [UNIT-1:0]       dat_i,
    input  logic                  din_l,
    input  logic                  din_r,
    input  logic                  frame_m,
    input  logic                  blank_n,
    output logic [NOUT*LVL_W-1:0] lvl_o
);
    logic            seg_go, line_go;
    logic [NOUT-1:0] sr_q, lat_q;

    assign seg_go  = shift_stb & ~en_n & ~mode_common;
    assign line_go = latch_stb & ~en_n;

    lcd_seg_shifter #(.NOUT(NOUT), .UNIT(UNIT)) u_seg (
        .clk(clk), .rst(rst), .go(seg_go), .wide(bus_wide),
        .rev(shift_rev), .dat(dat_i), .sr_o(sr_q)
    );

    lcd_line_reg #(.NOUT(NOUT)) u_line (
        .clk(clk), .rst(rst), .go(line_go), .common(mode_common),
        .dual(dual_half), .rev(shift_rev), .din_l(din_l), .din_r(din_r),
        .sr_in(sr_q), .lat_o(lat_q)
    );

    lcd_level_map #(.NOUT(NOUT)) u_map (
        .common(mode_common), .m(frame_m), .show(blank_n),
        .lat(lat_q), .lvl(lvl_o)
    );
endmodule

// File: rtl/lcd_drive_core_chk.sv
module lcd_drive_core_chk #(
    parameter int NOUT = 80,
    parameter int UNIT = 4,
    parameter int LW   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               en_n,
    input logic               shift_stb,
    input logic               latch_stb,
    input logic               mode_common,
    input logic               shift_rev,
    input logic               bus_wide,
    input logic [UNIT-1:0]    dat_i,
    input logic [NOUT-1:0]    sr_q,
    input logic [NOUT-1:0]    lat_q,
    input logic [NOUT*LW-1:0] lvl_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sr_q == '0) && (lat_q == '0));

    // R8
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        en_n |=> $stable(sr_q) && $stable(lat_q));

    // R5
    latch_copies_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && latch_stb && !mode_common) |=> lat_q == $past(sr_q));

    // R5
    latch_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !latch_stb |=> $stable(lat_q));

    // R6
    seg_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        mode_common |=> $stable(sr_q));

    // R2
    serial_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && shift_stb && !mode_common && !bus_wide && !shift_rev)
        |=> (sr_q[0] == $past(dat_i[0])) && (sr_q[NOUT-1:1] == $past(sr_q[NOUT-2:0])));

    // R3
    nibble_up_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_n && shift_stb && !mode_common && bus_wide && !shift_rev)
        |=> sr_q[UNIT-1:0] == $past(dat_i));

    for (genvar i = 0; i < NOUT; i++) begin : g_rng
        // R9 R10
        level_range_chk: assert property (@(posedge clk) disable iff (rst)
            lvl_o[i*LW +: LW] <= LW'(5));
    end
endmodule

bind lcd_drive_core lcd_drive_core_chk #(.NOUT(NOUT), .UNIT(UNIT), .LW(lcd_drv_pkg::LVL_W)) u_chk (
    .clk(clk), .rst(rst), .en_n(en_n), .shift_stb(shift_stb),
    .latch_stb(latch_stb), .mode_common(mode_common), .shift_rev(shift_rev),
    .bus_wide(bus_wide), .dat_i(dat_i), .sr_q(sr_q), .lat_q(lat_q), .lvl_o(lvl_o)
);

// File: tb/sim_lcd_drive_core.sv
`timescale 1ns/1ps
module sim_lcd_drive_core;
    localparam int N = 80;

    logic clk = 1'b0;
    logic rst = 1'b1, en_n = 1'b0, shift_stb = 1'b0, latch_stb = 1'b0;
    logic mode_common = 1'b0, dual_half = 1'b0, shift_rev = 1'b0, bus_wide = 1'b0;
    logic [3:0] dat_i = '0;
    logic din_l = 1'b0, din_r = 1'b0, frame_m = 1'b0, blank_n = 1'b1;
    logic [N*3-1:0] lvl_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lcd_drive_core u0 (
        .clk(clk), .rst(rst), .en_n(en_n), .shift_stb(shift_stb),
        .latch_stb(latch_stb), .mode_common(mode_common), .dual_half(dual_half),
        .shift_rev(shift_rev), .bus_wide(bus_wide), .dat_i(dat_i),
        .din_l(din_l), .din_r(din_r), .frame_m(frame_m), .blank_n(blank_n),
        .lvl_o(lvl_o)
    );

    // fields {common, m, fill, expected level}
    localparam logic [5:0] TBL [8] = '{
        {1'b0, 1'b0, 1'b1, 3'd0}, {1'b0, 1'b1, 1'b1, 3'd5},
        {1'b0, 1'b0, 1'b0, 3'd2}, {1'b0, 1'b1, 1'b0, 3'd3},
        {1'b1, 1'b0, 1'b1, 3'd0}, {1'b1, 1'b1, 1'b1, 3'd5},
        {1'b1, 1'b0, 1'b0, 3'd1}, {1'b1, 1'b1, 1'b0, 3'd4}
    };

    function automatic int lv(input int i);
        return int'(lvl_o[i*3 +: 3]);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int exp);
        int bad = 0;
        for (int i = 0; i < N; i++) if (lv(i) != exp) bad++;
        check(req, bad, 0);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sh(input logic [3:0] d);
        dat_i = d; shift_stb = 1'b1; step(); shift_stb = 1'b0;
    endtask

    task automatic lt(input logic l, input logic r);
        din_l = l; din_r = r; latch_stb = 1'b1; step(); latch_stb = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        rst = 1'b0;
        // R1: cleared register, segment mode, M=0 -> non-selected level 2
        check_all("R1 reset state", 2);

        // R9 R10: level table
        for (int t = 0; t < 8; t++) begin
            do_reset();
            mode_common = TBL[t][5]; frame_m = TBL[t][4];
            dual_half = 1'b0; shift_rev = 1'b0; bus_wide = 1'b1;
            if (!TBL[t][5]) begin
                for (int k = 0; k < 20; k++) sh(TBL[t][3] ? 4'hF : 4'h0);
                lt(1'b0, 1'b0);
            end else begin
                for (int k = 0; k < N; k++) lt(TBL[t][3], 1'b0);
            end
            check_all(TBL[t][3] ? "R9 selected level" : "R10 non-selected level",
                      int'(TBL[t][2:0]));
        end

        // R2: serial, upward
        do_reset();
        mode_common = 1'b0; frame_m = 1'b0; bus_wide = 1'b0; shift_rev = 1'b0;
        sh(4'h1);
        for (int k = 0; k < N-1; k++) sh(4'h0);
        check("R5 no change before latch", lv(79), 2);
        lt(1'b0, 1'b0);
        check("R2 first bit at 79", lv(79), 0);
        check("R2 bit 78 clear", lv(78), 2);

        // R4: serial, downward
        do_reset();
        shift_rev = 1'b1;
        sh(4'h1);
        for (int k = 0; k < N-1; k++) sh(4'h0);
        lt(1'b0, 1'b0);
        check("R4 first bit at 0", lv(0), 0);
        check("R4 bit 79 clear", lv(79), 2);

        // R3: nibble, upward and downward
        do_reset();
        bus_wide = 1'b1; shift_rev = 1'b0;
        sh(4'b1010);
        lt(1'b0, 1'b0);
        check("R3 nibble bit1", lv(1), 0);
        check("R3 nibble bit0", lv(0), 2);
        check("R3 nibble bit3", lv(3), 0);
        do_reset();
        sh(4'b0001);
        for (int k = 0; k < 19; k++) sh(4'h0);
        lt(1'b0, 1'b0);
        check("R3 20 nibbles land at 76", lv(76), 0);
        check("R3 bit 77 clear", lv(77), 2);
        do_reset();
        shift_rev = 1'b1;
        sh(4'b1000);
        for (int k = 0; k < 19; k++) sh(4'h0);
        lt(1'b0, 1'b0);
        check("R3 reverse lands at 3", lv(3), 0);
        check("R3 reverse bit 2 clear", lv(2), 2);

        // R8: disabled chip ignores strobes
        en_n = 1'b1;
        for (int k = 0; k < 20; k++) sh(4'hF);
        lt(1'b0, 1'b0);
        check("R8 output unchanged bit3", lv(3), 0);
        check("R8 output unchanged bit2", lv(2), 2);
        en_n = 1'b0;
        lt(1'b0, 1'b0);
        check("R8 shifter unchanged after enable", lv(2), 2);

        // R11: blanking
        frame_m = 1'b1;
        blank_n = 1'b0; step();
        check_all("R11 blank level", 0);
        blank_n = 1'b1; step();
        check("R11 restore bit3", lv(3), 5);
        check("R11 restore bit2", lv(2), 3);
        frame_m = 1'b0;

        // R6: common single
        do_reset();
        mode_common = 1'b1; dual_half = 1'b0; shift_rev = 1'b0;
        lt(1'b1, 1'b0); lt(1'b0, 1'b0); lt(1'b0, 1'b0);
        check("R6 scan bit at 2", lv(2), 0);
        check("R6 common non-selected", lv(1), 1);
        sh(4'hF); sh(4'hF);
        check("R6 shift strobe ignored", lv(2), 0);
        check("R6 shift strobe ignored bit3", lv(3), 1);
        shift_rev = 1'b1;
        lt(1'b0, 1'b1);
        check("R6 reverse entry at 79", lv(79), 0);
        check("R6 reverse moves down", lv(1), 0);

        // R7: dual halves
        do_reset();
        dual_half = 1'b1; shift_rev = 1'b0;
        lt(1'b1, 1'b0);
        lt(1'b0, 1'b1);
        check("R7 low half at 1", lv(1), 0);
        check("R7 high half at 40", lv(40), 0);
        for (int k = 0; k < 38; k++) lt(1'b0, 1'b0);
        check("R7 low half top", lv(39), 0);
        lt(1'b0, 1'b0);
        check("R7 no spill into high half", lv(40), 1);
        check("R7 high half top", lv(79), 0);
        do_reset();
        shift_rev = 1'b1;
        lt(1'b1, 1'b1);
        check("R7 reverse low half entry 39", lv(39), 0);
        check("R7 reverse high half entry 79", lv(79), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule